// File: doc/BRIEF.md
# Serial Configuration Loader for a Programmable Device

This block brings up a downstream programmable device by pushing a configuration bitstream into it over a one-bit serial link. A pulse on `start_i` makes it pull the active-low program line down for a fixed time and then release it. It then waits for the device to report that its configuration memory is cleared, which the device does by raising its init line. Once init is high, the block takes bitstream bytes from a valid/ready byte port and shifts each byte out, low bit first, on a data line. A configuration clock carries the data into the device. After the byte marked last has been shifted, the block waits for the done line to rise.

The block can end a run in one of four ways. A successful run raises `ok_o`. A failed run returns a 2-bit code on `err_o`: 1 when init never rose, 2 when init dropped during the done wait (a checksum failure), and 3 when done never rose. All delays and time limits are counted in microsecond ticks. The ticks come from a divider of `TICK_DIV` system cycles. The divider and the tick count both restart each time a timed state is entered.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset the block is idle. `busy_o`=0, `prog_n_o`=1, `cclk_o`=0, `byte_ready_o`=0, `ok_o`=0 and `err_o`=0.
- R2: A start accepted while idle holds `prog_n_o` low for exactly `PROG_US`*`TICK_DIV` system cycles. It then releases the line high, and the line stays high until the next accepted start.
- R3: If the synchronized init input has not been seen high within `INIT_TO_US` ticks after the program line is released, the run ends. `err_o`=1, `ok_o`=0, and no configuration clock pulse is issued.
- R4: `byte_ready_o` is high only while the block waits for a byte after init was seen. A byte is taken on a clock edge where valid and ready are both high. The byte taken with `byte_last_i`=1 is the final one.
- R5: Each byte is sent as 8 bits, bit 0 first. A bit is put on `dout_o` while `cclk_o` is low. `cclk_o` is then high for exactly one cycle. `dout_o` holds through that high cycle and the low cycle after it.
- R6: After the final bit, a rise of `done_i` ends the run with `ok_o`=1 and `err_o`=0. The result appears on the third rising clock edge after the change of `done_i`, which includes two synchronizer stages.
- R7: If init is low while the block waits for done (and done is low), the run ends with `err_o`=2. The result appears on the third rising edge after init falls.
- R8: If done has not risen within `DONE_TO_US` ticks after the final bit, the run ends with `err_o`=3.
- R9: `start_i` has no effect while `busy_o` is high. The program line is not pulsed again and the bit stream carries on unchanged.
- R10: `ok_o` and `err_o` hold their final values until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a configuration run when idle |
| byte_data_i | input | 8 | Bitstream byte |
| byte_valid_i | input | 1 | Byte is valid |
| byte_last_i | input | 1 | Byte is the final one of the bitstream |
| byte_ready_o | output | 1 | Block can take a byte this cycle |
| prog_n_o | output | 1 | Active-low program line to the device |
| cclk_o | output | 1 | Configuration clock to the device |
| dout_o | output | 1 | Serial configuration data to the device |
| init_i | input | 1 | Device init status, asynchronous |
| done_i | input | 1 | Device done status, asynchronous |
| busy_o | output | 1 | A run is in progress |
| ok_o | output | 1 | Last run succeeded |
| err_o | output | 2 | Last run error code: 0 none, 1 init timeout, 2 checksum, 3 done timeout |

## Verification
The program pulse is measured by counting the rising edges at which `prog_n_o` is low, and it must come to exactly `PROG_US`*`TICK_DIV` cycles. A change on `done_i` or `init_i` is driven at a falling edge. The bench then samples at the second falling edge after it, where the run must still be busy with no result. It samples again at the third falling edge, where the result must be present. This follows from two synchronizer flops plus the state register. Bits are captured on each rise of `cclk_o`. Byte handshakes are decided from `byte_ready_o` read at the falling edge before the accepting rising edge. The end results are read only after `busy_o` has dropped.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int TICK_DIV   = 125,
  parameter int PROG_US    = 10,
  parameter int INIT_TO_US = 500,
  parameter int DONE_TO_US = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] byte_data_i,
  input  logic       byte_valid_i,
  input  logic       byte_last_i,
  output logic       byte_ready_o,
  output logic       prog_n_o,
  output logic       cclk_o,
  output logic       dout_o,
  input  logic       init_i,
  input  logic       done_i,
  output logic       busy_o,
  output logic       ok_o,
  output logic [1:0] err_o
);
  localparam int DW    = $clog2(TICK_DIV + 1);
  localparam int MAXUS = (DONE_TO_US > INIT_TO_US) ?
                         ((DONE_TO_US > PROG_US) ? DONE_TO_US : PROG_US) :
                         ((INIT_TO_US > PROG_US) ? INIT_TO_US : PROG_US);
  localparam int CW    = $clog2(MAXUS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_WINIT, S_GETB, S_SETUP, S_HIGH, S_FALL, S_WDONE
  } st_t;

  st_t          st;
  logic [DW-1:0] div;
  logic [CW-1:0] cnt;
  logic [7:0]   sh;
  logic [2:0]   bitn;
  logic         last;
  logic [1:0]   init_q, done_q;
  logic         tick;

  wire init_s = init_q[1];
  wire done_s = done_q[1];

  assign tick         = (div == DW'(TICK_DIV - 1));
  assign byte_ready_o = (st == S_GETB);
  assign prog_n_o     = (st != S_PROG);
  assign cclk_o       = (st == S_HIGH);
  assign dout_o       = sh[0];
  assign busy_o       = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
      done_q <= '0;
    end else begin
      init_q <= {init_q[0], init_i};
      done_q <= {done_q[0], done_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      div  <= '0;
      cnt  <= '0;
      sh   <= '0;
      bitn <= '0;
      last <= 1'b0;
      ok_o <= 1'b0;
      err_o <= 2'd0;
    end else begin
      div <= tick ? '0 : div + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
      case (st)
        S_IDLE:
          if (start_i) begin
            st <= S_PROG;
            ok_o <= 1'b0;
            err_o <= 2'd0;
            div <= '0;
            cnt <= '0;
          end
        S_PROG:
          if (tick && cnt == CW'(PROG_US - 1)) begin
            st  <= S_WINIT;
            div <= '0;
            cnt <= '0;
          end
        S_WINIT:
          if (init_s) st <= S_GETB;
          else if (tick && cnt == CW'(INIT_TO_US - 1)) begin
            st <= S_IDLE;
            err_o <= 2'd1;
          end
        S_GETB:
          if (byte_valid_i) begin
            sh   <= byte_data_i;
            last <= byte_last_i;
            bitn <= '0;
            st   <= S_SETUP;
          end
        S_SETUP: st <= S_HIGH;
        S_HIGH:  st <= S_FALL;
        S_FALL: begin
          sh   <= {1'b0, sh[7:1]};
          bitn <= bitn + 1'b1;
          if (bitn != 3'd7) st <= S_SETUP;
          else if (!last)   st <= S_GETB;
          else begin
            st  <= S_WDONE;
            div <= '0;
            cnt <= '0;
          end
        end
        S_WDONE:
          if (done_s) begin
            st <= S_IDLE;
            ok_o <= 1'b1;
          end else if (!init_s) begin
            st <= S_IDLE;
            err_o <= 2'd2;
          end else if (tick && cnt == CW'(DONE_TO_US - 1)) begin
            st <= S_IDLE;
            err_o <= 2'd3;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module serial_cfg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       prog_n_o,
  input logic       cclk_o,
  input logic       dout_o,
  input logic       byte_ready_o,
  input logic       ok_o,
  input logic [1:0] err_o
);
  // R1
  ok_has_no_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> err_o == 2'd0);

  // R2
  prog_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> busy_o);

  // R4
  ready_context_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> (busy_o && prog_n_o && !cclk_o));

  // R5
  cclk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_o |=> !cclk_o);

  // R5
  data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_o |=> $stable(dout_o));

  // R9
  prog_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_n_o) |-> $past(!busy_o) && $past(start_i));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o) && $past(!start_i)) |-> ($stable(ok_o) && $stable(err_o)));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (.*);

// File: tb/test_serial_cfg_loader.sv
module test_serial_cfg_loader;
  localparam int TD = 4, PUS = 3, IUS = 20, DUS = 40;
  localparam int NEVER = 255;

  typedef struct packed {
    logic [7:0] init_dly;
    logic       crc;
    logic [7:0] done_dly;
    logic [3:0] nbytes;
    logic [1:0] exp_err;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{8'd5,   1'b0, 8'd4,   4'd3, 2'd0},
    '{8'd255, 1'b0, 8'd0,   4'd2, 2'd1},
    '{8'd2,   1'b1, 8'd0,   4'd2, 2'd2},
    '{8'd7,   1'b0, 8'd255, 4'd1, 2'd3},
    '{8'd0,   1'b0, 8'd3,   4'd4, 2'd0}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] bdata = 0;
  logic bvalid = 0, blast = 0, init = 0, done = 0;
  logic bready, prog_n, cclk, dout, busy, ok;
  logic [1:0] err;

  int tests = 0, fails = 0;
  int bits = 0, progc = 0;
  logic [7:0] cap [16];

  always #4 clk = ~clk;

  serial_cfg_loader #(.TICK_DIV(TD), .PROG_US(PUS), .INIT_TO_US(IUS), .DONE_TO_US(DUS))
  i_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .byte_data_i(bdata),
    .byte_valid_i(bvalid), .byte_last_i(blast), .byte_ready_o(bready),
    .prog_n_o(prog_n), .cclk_o(cclk), .dout_o(dout), .init_i(init),
    .done_i(done), .busy_o(busy), .ok_o(ok), .err_o(err));

  always @(posedge clk) if (rst_n && !prog_n) progc++;
  always @(posedge cclk) begin
    if (bits < 128) cap[bits/8][bits%8] = dout;
    bits++;
  end

  function automatic logic [7:0] bval(int s, int k);
    return 8'(8'h3C + s * 8'h51) ^ 8'(k * 8'h2B + 1);
  endfunction

  task automatic chk(logic cond, string req, int act, int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(int s, bit poke);
    vec_t v = VEC[s];
    bits = 0; progc = 0; init = 0; done = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy && !ok && err == 0, "R10 cleared on start", {ok, err}, 0);
    fork
      begin
        for (int k = 0; k < int'(v.nbytes); k++) begin
          bvalid = 1; bdata = bval(s, k); blast = (k == int'(v.nbytes) - 1);
          while (busy && !bready) @(negedge clk);
          if (!busy) break;
          @(negedge clk);
        end
        bvalid = 0; blast = 0;
      end
      begin
        while (busy && !prog_n) @(negedge clk);
        if (busy && v.init_dly != 8'(NEVER)) begin
          repeat (int'(v.init_dly)) @(negedge clk);
          init = 1;
        end
      end
      begin
        while (busy && bits < int'(v.nbytes) * 8) @(negedge clk);
        if (busy && v.crc) begin
          repeat (3) @(negedge clk);
          init = 0;
          @(negedge clk); @(negedge clk);
          chk(busy && err == 0, "R7 no code before third edge", err, 0);
          @(negedge clk);
          chk(!busy && err == 2, "R7 checksum code on third edge", err, 2);
        end else if (busy && v.done_dly != 8'(NEVER)) begin
          repeat (int'(v.done_dly)) @(negedge clk);
          done = 1;
          @(negedge clk); @(negedge clk);
          chk(busy && !ok, "R6 ok not before third edge", ok, 0);
          @(negedge clk);
          chk(!busy && ok && err == 0, "R6 ok on third edge", {ok, err}, 4);
        end
      end
      begin
        if (poke) begin
          while (busy && bits < 5) @(negedge clk);
          start = 1; @(negedge clk); start = 0;
        end
      end
    join
    while (busy) @(negedge clk);
    chk(err == v.exp_err, "R3/R7/R8 error code", err, int'(v.exp_err));
    chk(ok == (v.exp_err == 0), "R6 ok flag", ok, int'(v.exp_err == 0));
    chk(progc == PUS * TD, poke ? "R9 program not re-pulsed" : "R2 program pulse width",
        progc, PUS * TD);
    if (v.exp_err == 1)
      chk(bits == 0, "R3 no clock after init timeout", bits, 0);
    else begin
      chk(bits == int'(v.nbytes) * 8, "R4 bit count", bits, int'(v.nbytes) * 8);
      for (int k = 0; k < int'(v.nbytes); k++)
        chk(cap[k] == bval(s, k), "R5 byte lsb first", cap[k], bval(s, k));
    end
    repeat (10) @(negedge clk);
    chk(ok == (v.exp_err == 0) && err == v.exp_err && prog_n, "R10 result held",
        err, int'(v.exp_err));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && prog_n && !cclk && !bready && !ok && err == 0, "R1 reset state",
        {busy, prog_n, cclk, bready, ok, err}, 16);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !bready && prog_n, "R1 idle after reset", busy, 0);
    for (int s = 0; s < 5; s++) run(s, 1'b0);
    run(0, 1'b1);
    chk(ok && err == 0, "R9 start while busy ignored", err, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule